// File: doc/BRIEF.md
# Memory Cycle Sequencer with DMA Priority

This block arbitrates access to a core memory between a processor and a DMA channel and times each granted access as a fixed sequence of reference ticks. Everything runs on one system clock. A single-cycle `tick` enable marks the 200 ns reference grid, and every decision is taken on a clock where `tick` is high. When both requesters are waiting at a cycle boundary, the DMA channel is always served first. It may keep the memory for as many consecutive cycles as it keeps requesting. While it does, a pending processor access is frozen through the `hold` output.

A full cycle spans five ticks and is either a clear/write or a read/restore. The processor may also ask for a half cycle, which is a read that spans three ticks. The memory array itself is represented only by the read strobe, the read-data-valid window and the write strobe. All signals are active high. Requests are levels that are sampled on the tick.

Top module: `memseq_arb`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `hold`, `rd_strobe`, `rd_valid` and `wr_strobe` are all low after that edge.
- R2: A cycle starts only on a clock where `tick` is high and `busy` is low. A request without a tick, or while busy, starts nothing. `busy` goes high after the start edge.
- R3: A full cycle keeps `busy` high for exactly four tick periods. `busy` falls on the fifth tick counted from the start tick, and the next tick may start a new cycle.
- R4: A processor start with `cpu_half` high gives a half cycle: `busy` stays high for two tick periods and falls on the third tick.
- R5: When `dma_req` and `cpu_req` are both high on a start tick, the DMA cycle is started and `hold` goes high after that edge.
- R6: A DMA request present at a boundary tick always starts another DMA cycle. A processor cycle starts only on a boundary tick where `dma_req` is low.
- R7: `hold` stays high through consecutive DMA cycles. It falls on the closing tick of a DMA cycle when `dma_req` is low there, and it is low during any processor cycle.
- R8: `dma_wr` is sampled only on the DMA start tick. High selects clear/write, and `wr_strobe` is then high in tick periods 3 and 4. Changes later in the cycle have no effect.
- R9: In a full read cycle (DMA with `dma_wr` low, or any processor full cycle), `rd_strobe` is high in tick periods 1 and 2 and `rd_valid` in periods 3 and 4. In a half cycle, `rd_strobe` is high in period 1 and `rd_valid` in period 2. At most one of the three strobes is high at a time, and only while `busy` is high.
- R10: `cpu_half` has no effect on a DMA cycle, which is always full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock reference tick enable |
| cpu_req | input | 1 | Processor memory microcommand pending |
| cpu_half | input | 1 | Processor asks for a half cycle |
| dma_req | input | 1 | DMA channel requests a cycle |
| dma_wr | input | 1 | DMA cycle type: 1 clear/write, 0 read/restore |
| busy | output | 1 | Memory cycle in progress |
| hold | output | 1 | Processor clock freeze |
| rd_strobe | output | 1 | Read phase of the memory array |
| rd_valid | output | 1 | Read data valid window |
| wr_strobe | output | 1 | Write data taken by the memory |

## Verification
The bench targets the boundary tick, where the closing of one cycle and the start of the next are one tick apart. A design that starts on the closing tick would shorten every cycle, and one that waits an extra tick would stretch it. Simultaneous requests and a DMA request that persists across two cycles check priority and the release of `hold`. A wrong design would give the processor the memory or release the freeze one cycle early. Toggling `dma_wr` and `cpu_half` after the start, and asking for a half cycle with DMA, expose type selection that samples on the wrong clock.

// File: rtl/memseq_arb.sv
module memseq_arb #(
  parameter int FULL_TICKS = 5,
  parameter int HALF_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cpu_req,
  input  logic cpu_half,
  input  logic dma_req,
  input  logic dma_wr,
  output logic busy,
  output logic hold,
  output logic rd_strobe,
  output logic rd_valid,
  output logic wr_strobe
);
  localparam int PW = $clog2(FULL_TICKS);
  localparam logic [PW-1:0] FULL_LAST = PW'(FULL_TICKS - 1);
  localparam logic [PW-1:0] HALF_LAST = PW'(HALF_TICKS - 1);
  localparam logic [PW-1:0] SPLIT     = PW'((FULL_TICKS - 1) / 2);

  logic          busy_q, hold_q, half_q, wr_q, dma_q;
  logic [PW-1:0] ph_q;

  wire idle_tick = tick & ~busy_q;
  wire go_dma    = idle_tick & dma_req;
  wire go_cpu    = idle_tick & ~dma_req & cpu_req;
  wire [PW-1:0] last_ph = half_q ? HALF_LAST : FULL_LAST;
  wire done      = tick & busy_q & (ph_q == last_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      half_q <= 1'b0;
      wr_q   <= 1'b0;
      dma_q  <= 1'b0;
      ph_q   <= '0;
    end else begin
      if (go_dma | go_cpu) begin
        busy_q <= 1'b1;
        ph_q   <= PW'(1);
        half_q <= go_cpu & cpu_half;
        wr_q   <= go_dma & dma_wr;
        dma_q  <= go_dma;
      end else if (done) begin
        busy_q <= 1'b0;
        ph_q   <= '0;
      end else if (tick & busy_q) begin
        ph_q   <= ph_q + PW'(1);
      end

      if (go_dma)
        hold_q <= cpu_req;
      else if (idle_tick)
        hold_q <= 1'b0;
      else if (done & dma_q & ~dma_req)
        hold_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign hold      = hold_q;
  assign rd_strobe = busy_q & ~wr_q & (half_q ? (ph_q < HALF_LAST) : (ph_q <= SPLIT));
  assign rd_valid  = busy_q & ~wr_q & (half_q ? (ph_q == HALF_LAST) : (ph_q > SPLIT));
  assign wr_strobe = busy_q & wr_q & (ph_q > SPLIT);
endmodule

// File: rtl/memseq_arb_chk.sv
module memseq_arb_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic cpu_req,
  input logic dma_req,
  input logic busy,
  input logic hold,
  input logic rd_strobe,
  input logic rd_valid,
  input logic wr_strobe
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !busy && !hold) // R1
    else $error("reset state");
  AST_NO_START_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(busy)) // R2
    else $error("busy moved without tick");
  AST_START_ON_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && (dma_req || cpu_req)) |=> busy) // R2
    else $error("request not started");
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && !dma_req && !cpu_req) |=> !busy && !hold) // R7
    else $error("spurious start");
  AST_DMA_FREEZES_CPU: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && dma_req && cpu_req) |=> hold) // R5
    else $error("hold missing on DMA grant");
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_strobe, rd_valid, wr_strobe})) // R9
    else $error("strobes overlap");
  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || rd_valid || wr_strobe) |-> busy) // R9
    else $error("strobe outside cycle");
endmodule

bind memseq_arb memseq_arb_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cpu_req(cpu_req), .dma_req(dma_req),
  .busy(busy), .hold(hold), .rd_strobe(rd_strobe), .rd_valid(rd_valid),
  .wr_strobe(wr_strobe)
);

// File: tb/tb_memseq_arb.sv
`timescale 1ns/1ps
module tb_memseq_arb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, cpu_req = 1'b0, cpu_half = 1'b0, dma_req = 1'b0, dma_wr = 1'b0;
  logic busy, hold, rd_strobe, rd_valid, wr_strobe;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  memseq_arb dut (
    .clk(clk), .rst(rst), .tick(tick), .cpu_req(cpu_req), .cpu_half(cpu_half),
    .dma_req(dma_req), .dma_wr(dma_wr), .busy(busy), .hold(hold),
    .rd_strobe(rd_strobe), .rd_valid(rd_valid), .wr_strobe(wr_strobe)
  );

  // reference model state
  bit m_busy, m_hold, m_half, m_wr, m_dma;
  int m_ph;

  function automatic bit e_rds();
    return m_busy && !m_wr && (m_half ? (m_ph == 1) : (m_ph <= 2));
  endfunction
  function automatic bit e_rdv();
    return m_busy && !m_wr && (m_half ? (m_ph == 2) : (m_ph >= 3));
  endfunction
  function automatic bit e_wrs();
    return m_busy && m_wr && (m_ph >= 3);
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_busy = 0; m_hold = 0; m_half = 0; m_wr = 0; m_dma = 0; m_ph = 0;
    end else if (tick) begin
      if (!m_busy) begin
        if (dma_req) begin
          m_busy = 1; m_ph = 1; m_half = 0; m_wr = dma_wr; m_dma = 1; m_hold = cpu_req;
        end else if (cpu_req) begin
          m_busy = 1; m_ph = 1; m_half = cpu_half; m_wr = 0; m_dma = 0; m_hold = 0;
        end else m_hold = 0;
      end else if (m_ph == (m_half ? 2 : 4)) begin
        m_busy = 0; m_ph = 0;
        if (m_dma && !dma_req) m_hold = 0;
      end else m_ph = m_ph + 1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 busy", busy, m_busy);
    chk("R7 hold", hold, m_hold);
    chk("R9 rd_strobe", rd_strobe, e_rds());
    chk("R9 rd_valid", rd_valid, e_rdv());
    chk("R8 wr_strobe", wr_strobe, e_wrs());
  endtask

  // inputs set at negedge, model follows the edge, outputs compared at next negedge
  task automatic drive(input bit t, input bit d, input bit dw, input bit c, input bit ch);
    tick = t; dma_req = d; dma_wr = dw; cpu_req = c; cpu_half = ch;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic tk(input bit d, input bit dw, input bit c, input bit ch);
    drive(1'b1, d, dw, c, ch);
    drive(1'b0, d, dw, c, ch);
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    drive(0, 0, 0, 0, 0);
    drive(1, 1, 1, 1, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset hold", hold, 0);
    rst = 1'b0;
    drive(0, 0, 0, 0, 0);

    // R2: requests without tick start nothing; idle tick starts nothing
    drive(0, 1, 0, 1, 0);
    chk("R2 no tick no start", busy, 0);
    tk(0, 0, 0, 0);
    chk("R2 idle tick", busy, 0);

    // back to back DMA write then read, processor frozen, then processor read
    tk(1, 1, 1, 0);
    chk("R5 dma wins busy", busy, 1);
    chk("R5 dma wins hold", hold, 1);
    tk(1, 0, 1, 0);
    tk(1, 0, 1, 0);
    chk("R8 write ignores late dma_wr", wr_strobe, 1);
    tk(1, 0, 1, 0);
    tk(1, 0, 1, 0);
    chk("R3 busy falls fifth tick", busy, 0);
    chk("R7 hold kept for next dma", hold, 1);
    tk(1, 0, 1, 0);
    chk("R6 back to back dma", rd_strobe, 1);
    chk("R6 hold continues", hold, 1);
    tk(0, 0, 1, 0);
    tk(0, 0, 1, 0);
    chk("R9 dma read valid", rd_valid, 1);
    tk(0, 0, 1, 0);
    tk(0, 0, 1, 0);
    chk("R7 hold released", hold, 0);
    tk(0, 0, 1, 0);
    chk("R6 cpu after dma", busy, 1);
    chk("R7 hold low in cpu cycle", hold, 0);
    repeat (4) tk(0, 0, 0, 0);

    // R4 half cycle
    tk(0, 0, 1, 1);
    chk("R4 half rd_strobe", rd_strobe, 1);
    tk(0, 0, 0, 0);
    chk("R4 half rd_valid", rd_valid, 1);
    tk(0, 0, 0, 0);
    chk("R4 half ends third tick", busy, 0);

    // R10 DMA ignores cpu_half
    tk(1, 0, 0, 1);
    tk(0, 0, 0, 1);
    tk(0, 0, 0, 1);
    chk("R10 dma full length", busy, 1);
    tk(0, 0, 0, 0);
    tk(0, 0, 0, 0);
    chk("R10 dma ends fifth tick", busy, 0);

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      bit t, d, c;
      t = ($urandom % 3) != 0;
      d = ($urandom % 4) == 0;
      c = ($urandom % 2) == 0;
      drive(t, d, $urandom % 2, c, $urandom % 2);
    end

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule